// File: doc/BRIEF.md
# CAS-before-RAS Refresh and Initialisation Sequencer

This block keeps a dynamic RAM alive. It first brings the memory out of power-up, then refreshes it periodically. After reset it holds off for a programmable settling pause. It then runs a burst of refresh cycles and raises `init_done`, which tells the access controller that normal traffic may begin. From then on it schedules one refresh cycle per row interval. The interval is the refresh period divided by the row count. The memory's internal row counter chooses the row, so the sequencer never drives an address.

The sequencer shares the strobe pins with the access controller. When it needs a cycle, it raises `bus_req` and keeps it raised until `bus_gnt` arrives. While granted, it drives the row strobe and every column-strobe lane itself. In each refresh cycle the column strobes fall first, the row strobe follows, and write enable stays high. A grant can come late. The sequencer counts each interval tick that has not been served, so no refresh is lost. If the backlog would reach the configured limit, the refresh period may have been broken. In that case the sequencer flags an overflow and runs the whole pause-and-burst start-up again.

Top module: `cbr_refresh_seq`

## Requirements
- R1: For PAUSE_US*CLK_MHZ clock cycles after reset is released, `bus_req` stays low, `ras_n` and every `cas_n` lane stay high, and `init_done` stays low.
- R2: After the pause, exactly INIT_BURST refresh cycles (falling edges of `ras_n`) take place. `init_done` then rises, and no further refresh begins for at least one interval.
- R3: `bus_req` stays high until a grant is received and refresh work is still owed. No strobe is ever low while `bus_gnt` is low.
- R4: Every column-strobe lane goes low at least T_CSR_CYC cycles before `ras_n` falls and is still low when it falls. `we_n` is high whenever `ras_n` falls.
- R5: After `ras_n` falls, the column strobes stay low for at least T_CHR_CYC cycles and then rise while `ras_n` is still low. `ras_n` stays low for at least T_RAS_CYC cycles in total and rises only with the column strobes high.
- R6: Between two refresh cycles, `ras_n` stays high for at least T_RP_CYC + T_CSR_CYC cycles.
- R7: Once `init_done` is high and the grant is given freely, one refresh cycle is issued per (PERIOD_US*CLK_MHZ)/ROWS clock cycles.
- R8: Interval ticks that arrive while the grant is withheld are counted. Once the grant returns, every counted refresh is carried out, back to back.
- R9: If an interval tick arrives while PEND_LIMIT-1 refreshes are already owed, `ovf_err` pulses high for exactly one cycle. `init_done` falls on the next cycle, and the full pause and INIT_BURST sequence runs again before `init_done` returns.
- R10: All NUM_CAS column-strobe lanes always carry the same level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_gnt | input | 1 | Access controller hands the strobe pins to the sequencer |
| bus_req | output | 1 | Sequencer asks for the strobe pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | NUM_CAS | Column strobe lanes, active low, driven identically |
| we_n | output | 1 | Write enable, held high (inactive) |
| init_done | output | 1 | Start-up pause and burst complete; normal access allowed |
| ovf_err | output | 1 | One-cycle pulse when the refresh backlog overflows |

## Verification
The bench builds the block with a 1 MHz notional clock. This gives a 30-cycle pause and a 40-cycle refresh interval. Start-up, steady-state pacing and whole overflow episodes therefore fit into a few thousand cycles. It uses a backlog limit of 6 with an 8-cycle burst, which allows a grant to be withheld for more than four intervals without overflow. Withholding it for six intervals then forces the overflow and re-initialisation path. Strobe phases of 2/2/5/3 cycles make every phase span more than one clock. This lets the pin monitor tell a lead, hold or precharge that is one cycle short from a correct one.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

   typedef enum logic [2:0] {
      ST_PAUSE,   // power-up settling wait
      ST_IDLE,    // nothing owed or just finished a cycle
      ST_REQ,     // waiting for the strobe pins
      ST_CSR,     // column strobes low, row strobe high
      ST_LOCAS,   // both strobes low
      ST_LORAS,   // row strobe low, column strobes released
      ST_PRE      // row precharge
   } seq_st_t;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer #(
   parameter int INTERVAL_CYC = 781
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = $clog2(INTERVAL_CYC);

   logic [CW-1:0] cnt_q;
   logic          at_end;

   assign at_end = (cnt_q == CW'(INTERVAL_CYC - 1));
   assign tick   = run && at_end;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt_q <= '0;
      end else if (at_end) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/cbr_pend_ctr.sv
module cbr_pend_ctr #(
   parameter int PEND_LIMIT = 8,
   parameter int INIT_BURST = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_burst,
   input  logic tick,
   input  logic cyc_done,
   output logic pend_nz,
   output logic pend_one,
   output logic ovf_err
);
   localparam int PW = $clog2(cbr_pkg::imax(PEND_LIMIT, INIT_BURST) + 1);

   logic [PW-1:0] pend_q;
   logic          dec_ok;
   logic          go_up;
   logic          go_down;

   assign dec_ok   = cyc_done && (pend_q != '0);
   assign go_up    = tick && !dec_ok;
   assign go_down  = dec_ok && !tick;
   assign pend_nz  = (pend_q != '0);
   assign pend_one = (pend_q == PW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q  <= '0;
         ovf_err <= 1'b0;
      end else begin
         ovf_err <= 1'b0;
         if (load_burst) begin
            pend_q <= PW'(INIT_BURST);
         end else if (go_up) begin
            if (pend_q == PW'(PEND_LIMIT - 1)) begin
               ovf_err <= 1'b1;
               pend_q  <= '0;
            end else begin
               pend_q <= pend_q + 1'b1;
            end
         end else if (go_down) begin
            pend_q <= pend_q - 1'b1;
         end
      end
   end

endmodule

// File: rtl/cbr_strobe_fsm.sv
module cbr_strobe_fsm
   import cbr_pkg::*;
#(
   parameter int PAUSE_CYC = 20000,
   parameter int T_CSR_CYC = 1,
   parameter int T_CHR_CYC = 2,
   parameter int T_RAS_CYC = 7,
   parameter int T_RP_CYC  = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pend_nz,
   input  logic pend_one,
   input  logic ovf,
   input  logic bus_gnt,
   output logic bus_req,
   output logic ras_n,
   output logic cas_n,
   output logic load_burst,
   output logic cyc_done,
   output logic init_done
);
   localparam int PH_MAX = imax(imax(PAUSE_CYC, T_RAS_CYC), imax(T_CSR_CYC, T_RP_CYC));
   localparam int PH_W   = $clog2(PH_MAX + 1);

   seq_st_t         st_q, st_d;
   logic [PH_W-1:0] ph_q;
   logic            reinit_q;
   logic            restart;

   assign restart = ovf || reinit_q;

   always_comb begin
      st_d       = st_q;
      load_burst = 1'b0;
      cyc_done   = 1'b0;
      unique case (st_q)
         ST_PAUSE: begin
            if (ph_q == PH_W'(PAUSE_CYC - 1)) begin
               st_d       = ST_IDLE;
               load_burst = 1'b1;
            end
         end
         ST_IDLE: begin
            if (restart)      st_d = ST_PAUSE;
            else if (pend_nz) st_d = ST_REQ;
         end
         ST_REQ: begin
            if (restart)      st_d = ST_PAUSE;
            else if (bus_gnt) st_d = ST_CSR;
         end
         ST_CSR: begin
            if (ph_q == PH_W'(T_CSR_CYC - 1)) st_d = ST_LOCAS;
         end
         ST_LOCAS: begin
            if (ph_q == PH_W'(T_CHR_CYC - 1)) st_d = ST_LORAS;
         end
         ST_LORAS: begin
            if (ph_q == PH_W'(T_RAS_CYC - T_CHR_CYC - 1)) st_d = ST_PRE;
         end
         ST_PRE: begin
            if (ph_q == PH_W'(T_RP_CYC - 1)) begin
               cyc_done = 1'b1;
               st_d     = restart ? ST_PAUSE : ST_IDLE;
            end
         end
         default: st_d = ST_PAUSE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q      <= ST_PAUSE;
         ph_q      <= '0;
         reinit_q  <= 1'b0;
         init_done <= 1'b0;
      end else begin
         st_q <= st_d;
         ph_q <= (st_d != st_q) ? '0 : ph_q + 1'b1;
         if (st_d == ST_PAUSE && st_q != ST_PAUSE) begin
            reinit_q <= 1'b0;
         end else if (ovf) begin
            reinit_q <= 1'b1;
         end
         if (ovf) begin
            init_done <= 1'b0;
         end else if (cyc_done && pend_one && !reinit_q && !init_done) begin
            init_done <= 1'b1;
         end
      end
   end

   always_comb begin
      bus_req = (st_q == ST_REQ) || (st_q == ST_CSR) || (st_q == ST_LOCAS) ||
                (st_q == ST_LORAS) || (st_q == ST_PRE);
      ras_n   = !((st_q == ST_LOCAS) || (st_q == ST_LORAS));
      cas_n   = !((st_q == ST_CSR) || (st_q == ST_LOCAS));
   end

endmodule

// File: rtl/cbr_refresh_seq.sv
module cbr_refresh_seq #(
   parameter int CLK_MHZ    = 100,
   parameter int PAUSE_US   = 200,
   parameter int PERIOD_US  = 32000,
   parameter int ROWS       = 4096,
   parameter int INIT_BURST = 8,
   parameter int PEND_LIMIT = 8,
   parameter int T_CSR_CYC  = 1,
   parameter int T_CHR_CYC  = 2,
   parameter int T_RAS_CYC  = 7,
   parameter int T_RP_CYC   = 5,
   parameter int NUM_CAS    = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_gnt,
   output logic               bus_req,
   output logic               ras_n,
   output logic [NUM_CAS-1:0] cas_n,
   output logic               we_n,
   output logic               init_done,
   output logic               ovf_err
);
   localparam int PAUSE_CYC    = PAUSE_US * CLK_MHZ;
   localparam int INTERVAL_CYC = (PERIOD_US * CLK_MHZ) / ROWS;
   localparam int CYC_LEN      = T_CSR_CYC + T_RAS_CYC + T_RP_CYC + 3;

   if (PAUSE_CYC < 1 || INIT_BURST < 1 || PEND_LIMIT < 2 || NUM_CAS < 1 ||
       T_CSR_CYC < 1 || T_CHR_CYC < 1 || T_RP_CYC < 1 ||
       T_RAS_CYC <= T_CHR_CYC) begin : g_bad_cfg
      $error("cbr_refresh_seq: invalid count or timing parameter");
   end
   if (INTERVAL_CYC < 4 || INTERVAL_CYC <= CYC_LEN) begin : g_bad_interval
      $error("cbr_refresh_seq: interval shorter than one refresh cycle");
   end

   logic tick;
   logic pend_nz;
   logic pend_one;
   logic load_burst;
   logic cyc_done;
   logic cas_lane_n;

   cbr_interval_timer #(
      .INTERVAL_CYC(INTERVAL_CYC)
   ) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (init_done),
      .tick (tick)
   );

   cbr_pend_ctr #(
      .PEND_LIMIT(PEND_LIMIT),
      .INIT_BURST(INIT_BURST)
   ) u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_burst(load_burst),
      .tick      (tick),
      .cyc_done  (cyc_done),
      .pend_nz   (pend_nz),
      .pend_one  (pend_one),
      .ovf_err   (ovf_err)
   );

   cbr_strobe_fsm #(
      .PAUSE_CYC(PAUSE_CYC),
      .T_CSR_CYC(T_CSR_CYC),
      .T_CHR_CYC(T_CHR_CYC),
      .T_RAS_CYC(T_RAS_CYC),
      .T_RP_CYC (T_RP_CYC)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend_nz   (pend_nz),
      .pend_one  (pend_one),
      .ovf       (ovf_err),
      .bus_gnt   (bus_gnt),
      .bus_req   (bus_req),
      .ras_n     (ras_n),
      .cas_n     (cas_lane_n),
      .load_burst(load_burst),
      .cyc_done  (cyc_done),
      .init_done (init_done)
   );

   for (genvar g = 0; g < NUM_CAS; g++) begin : g_cas_lane
      assign cas_n[g] = cas_lane_n;
   end

   assign we_n = 1'b1;

endmodule

// File: rtl/cbr_refresh_seq_chk.sv
module cbr_refresh_seq_chk #(
   parameter int NUM_CAS = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_gnt,
   input logic               bus_req,
   input logic               ras_n,
   input logic [NUM_CAS-1:0] cas_n,
   input logic               init_done,
   input logic               ovf_err
);
   p_lanes_match_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_n == '0) || (cas_n == '1));

   p_strobe_granted_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n || (cas_n != '1)) |-> bus_gnt);

   p_cas_leads_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> ((cas_n == '0) && ($past(cas_n) == '0)));

   p_cas_high_at_ras_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> (cas_n == '1));

   p_ovf_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |=> !ovf_err);

   p_ovf_clears_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_err |=> !init_done);

   p_done_falls_on_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(init_done) |-> $past(ovf_err));

   p_req_during_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !ras_n |-> bus_req);

endmodule

bind cbr_refresh_seq cbr_refresh_seq_chk #(.NUM_CAS(NUM_CAS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .bus_gnt  (bus_gnt),
   .bus_req  (bus_req),
   .ras_n    (ras_n),
   .cas_n    (cas_n),
   .init_done(init_done),
   .ovf_err  (ovf_err)
);

// File: tb/cbr_refresh_seq_tb.sv
module cbr_refresh_seq_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_MHZ    = 1;
   localparam int PAUSE_US   = 30;
   localparam int ROWS       = 4096;
   localparam int INTERVAL   = 40;
   localparam int PERIOD_US  = INTERVAL * ROWS;
   localparam int PAUSE_CYC  = PAUSE_US * CLK_MHZ;
   localparam int INIT_BURST = 8;
   localparam int PEND_LIMIT = 6;
   localparam int T_CSR      = 2;
   localparam int T_CHR      = 2;
   localparam int T_RAS      = 5;
   localparam int T_RP       = 3;
   localparam int NUM_CAS    = 2;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               allow = 1'b1;
   logic               bus_gnt = 1'b0;
   logic               bus_req;
   logic               ras_n;
   logic [NUM_CAS-1:0] cas_n;
   logic               we_n;
   logic               init_done;
   logic               ovf_err;

   int checks = 0;
   int fails  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   // access controller model: grant once allowed, hold until request drops
   always_ff @(posedge clk) bus_gnt <= bus_req && (allow || bus_gnt);

   cbr_refresh_seq #(
      .CLK_MHZ   (CLK_MHZ),
      .PAUSE_US  (PAUSE_US),
      .PERIOD_US (PERIOD_US),
      .ROWS      (ROWS),
      .INIT_BURST(INIT_BURST),
      .PEND_LIMIT(PEND_LIMIT),
      .T_CSR_CYC (T_CSR),
      .T_CHR_CYC (T_CHR),
      .T_RAS_CYC (T_RAS),
      .T_RP_CYC  (T_RP),
      .NUM_CAS   (NUM_CAS)
   ) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_gnt  (bus_gnt),
      .bus_req  (bus_req),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .init_done(init_done),
      .ovf_err  (ovf_err)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // pin monitor, sampled on the falling clock edge
   int   fall_cnt = 0;
   int   ovf_cnt = 0;
   int   cas_run = 0;
   int   ras_low_run = 0;
   int   ras_high_run = 1000;
   logic p_ras = 1'b1;
   logic p_cas_low = 1'b0;
   logic p_ovf = 1'b0;

   always @(negedge clk) begin
      if (rst_n) begin
         logic cas_low;
         cas_low = (cas_n != '1);
         if (!ras_n || cas_low)
            check(bus_gnt == 1'b1, "R3", "strobe low without grant", int'(bus_gnt), 1);
         if (p_ras && !ras_n) begin
            check(cas_run >= T_CSR, "R4", "CAS lead cycles", cas_run, T_CSR);
            check(cas_n == '0, "R10", "lanes low at RAS fall", int'(cas_n), 0);
            check(we_n == 1'b1, "R4", "we_n at RAS fall", int'(we_n), 1);
            check(ras_high_run >= T_RP + T_CSR, "R6", "RAS high cycles", ras_high_run,
                  T_RP + T_CSR);
            fall_cnt++;
         end
         if (!ras_n && p_cas_low && !cas_low)
            check(ras_low_run >= T_CHR, "R5", "CAS hold after RAS fall", ras_low_run, T_CHR);
         if (!p_ras && ras_n) begin
            check(ras_low_run >= T_RAS, "R5", "RAS low cycles", ras_low_run, T_RAS);
            check(cas_n == '1, "R5", "lanes high at RAS rise", int'(cas_n), (1 << NUM_CAS) - 1);
         end
         if (ovf_err) begin
            check(!p_ovf, "R9", "ovf_err pulse length", int'(p_ovf), 0);
            if (!p_ovf) ovf_cnt++;
         end
         cas_run      = cas_low ? cas_run + 1 : 0;
         ras_low_run  = !ras_n ? ras_low_run + 1 : 0;
         ras_high_run = ras_n ? ras_high_run + 1 : 0;
         p_cas_low    = cas_low;
         p_ras        = ras_n;
         p_ovf        = ovf_err;
      end
   end

   task automatic wait_idle();
      int lows = 0;
      for (int i = 0; i < 2000 && lows < 2; i++) begin
         @(negedge clk);
         lows = bus_req ? 0 : lows + 1;
      end
   endtask

   task automatic wait_init_done();
      for (int i = 0; i < 3000 && !init_done; i++) @(negedge clk);
   endtask

   task automatic t_reset_pause();
      int bad = 0;
      int seen = 0;
      check(!bus_req && ras_n && (cas_n == '1) && !init_done && !ovf_err,
            "R1", "outputs idle in reset", int'(bus_req), 0);
      rst_n = 1'b1;
      for (int i = 0; i < PAUSE_CYC; i++) begin
         @(negedge clk);
         if (bus_req || !ras_n || (cas_n != '1) || init_done) bad++;
      end
      check(bad == 0, "R1", "activity during pause", bad, 0);
      for (int i = 0; i < 8 && !seen; i++) begin
         @(negedge clk);
         if (bus_req) seen = 1;
      end
      check(seen == 1, "R1", "request after pause", seen, 1);
   endtask

   task automatic t_init_burst();
      int f0 = 0;
      int f1;
      f0 = fall_cnt;
      wait_init_done();
      check(init_done == 1'b1, "R2", "init_done raised", int'(init_done), 1);
      check(fall_cnt - f0 == INIT_BURST, "R2", "burst refresh count", fall_cnt - f0, INIT_BURST);
      f1 = fall_cnt;
      repeat (INTERVAL - 2) @(negedge clk);
      check(fall_cnt == f1, "R2", "no refresh before first interval", fall_cnt - f1, 0);
   endtask

   task automatic t_steady_rate();
      int f0;
      int n;
      f0 = fall_cnt;
      repeat (10 * INTERVAL) @(negedge clk);
      n = fall_cnt - f0;
      check(n >= 9 && n <= 11, "R7", "refreshes in ten intervals", n, 10);
   endtask

   task automatic t_backlog();
      int o0;
      int f0;
      int n;
      wait_idle();
      o0 = ovf_cnt;
      allow = 1'b0;
      f0 = fall_cnt;
      repeat (4 * INTERVAL + INTERVAL / 4) @(negedge clk);
      check(fall_cnt == f0, "R3", "no refresh while grant withheld", fall_cnt - f0, 0);
      check(bus_req == 1'b1, "R3", "request held while ungranted", int'(bus_req), 1);
      check(ovf_cnt == o0, "R8", "no overflow below limit", ovf_cnt - o0, 0);
      allow = 1'b1;
      wait_idle();
      n = fall_cnt - f0;
      check(n >= 4 && n <= 8, "R8", "backlog refreshes served", n, 4);
   endtask

   task automatic t_overflow();
      int o0;
      int el = 0;
      int f0;
      int bad = 0;
      wait_idle();
      o0 = ovf_cnt;
      allow = 1'b0;
      for (int i = 0; i < 8 * INTERVAL && !ovf_err; i++) begin
         @(negedge clk);
         el++;
      end
      check(ovf_err == 1'b1, "R9", "overflow flagged", int'(ovf_err), 1);
      check(el > 5 * INTERVAL, "R9", "cycles until overflow", el, 5 * INTERVAL);
      @(negedge clk);
      check(init_done == 1'b0, "R9", "init_done cleared", int'(init_done), 0);
      check(ovf_cnt - o0 == 1, "R9", "overflow pulses", ovf_cnt - o0, 1);
      repeat (2) @(negedge clk);
      allow = 1'b1;
      f0 = fall_cnt;
      for (int i = 0; i < PAUSE_CYC - 4; i++) begin
         @(negedge clk);
         if (bus_req) bad++;
      end
      check(bad == 0, "R9", "pause repeated", bad, 0);
      wait_init_done();
      check(init_done == 1'b1, "R9", "init_done restored", int'(init_done), 1);
      check(fall_cnt - f0 == INIT_BURST, "R9", "burst repeated", fall_cnt - f0, INIT_BURST);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset_pause();
      t_init_burst();
      t_steady_rate();
      t_backlog();
      t_overflow();
      t_steady_rate();
      check(fall_cnt > 30, "R10", "monitored refresh cycles", fall_cnt, 30);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule